// File: doc/BRIEF.md
# Acquisition Capture Controller

This block sits in the programmable fabric between an embedded processor and an external memory. The processor drives it through a small register bus: it writes command codes that pick one of two daughter-board connectors (a direct plug or a cabled link), set a capture limit, and start, stop or reset an acquisition. The processor reads back the progress through a status register and a word-count register.

During a capture the block takes 16-bit result samples from whichever link is selected. It joins each pair of consecutive samples into one 32-bit word and writes the words one after another into the upper half of the external memory. The lower half of that memory belongs to other software and is never touched. A valid/ready write port stands in for the memory controller. The same connector choice steers both the incoming sample path and the serial control lines to and from the daughter board.

Top module: `acq_capture_ctrl`

## Requirements
- R1: After reset, status reads 0, count reads 0, the limit register reads MAX_BYTES, no write is requested and the direct connector is selected (link_sel_o = 0).
- R2: Register addresses: 0 = command (write, code in bits [2:0]), 1 = limit in bytes, 2 = status, 3 = completed word count. Status bits [1:0] hold the state (0 idle, 1 capturing, 2 done, 3 flushing), bit 2 the overflow flag and bit 3 the connector. Command codes are 1 select direct, 2 select cabled, 3 start, 4 stop and 5 clear. Any other code has no effect, and a stop outside a capture has no effect.
- R3: link_sel_o (0 direct, 1 cabled) picks the sample source and the control return line, and routes ctl_tx_i only to the chosen connector's control output. The other connector's control output stays 0. A select command is ignored while the state is capturing or flushing.
- R4: Two consecutive accepted samples form one write word. The first sample goes in bits [15:0] and the second in bits [31:16].
- R5: The first write of a capture goes to word address 2^(ADDR_W-1), the base of the upper half. Each later write goes one word higher. No write goes below that base.
- R6: A stop command ends sample intake. If one unpaired sample is left, it is written with bits [31:16] zero. The state then becomes done.
- R7: A write to the limit register stores the value clamped to MAX_BYTES and rounded down to a multiple of 4. A capture accepts no further samples once issued words times 4 reach the limit, and then ends in done. A limit of 0 ends at once with no write.
- R8: A sample that arrives while a write is stalled (valid and not ready) is dropped and sets the sticky overflow flag.
- R9: A start while capturing or flushing is ignored, and the partial data is kept. A start from idle or done clears the count and the overflow flag.
- R10: The clear command returns the state to idle, zeroes the count and the overflow flag, and withdraws any pending write. The connector choice and the limit are kept.
- R11: While a write waits for ready, mem_valid_o, mem_addr_o and mem_wdata_o hold steady.
- R12: The count register equals the number of completed writes of the current capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| link_sel_o | output | 1 | Active connector: 0 direct, 1 cabled |
| direct_valid_i | input | 1 | Sample strobe, direct link |
| direct_data_i | input | 16 | Sample, direct link |
| cable_valid_i | input | 1 | Sample strobe, cabled link |
| cable_data_i | input | 16 | Sample, cabled link |
| ctl_tx_i | input | CTL_W | Control lines towards the daughter board |
| ctl_direct_o | output | CTL_W | Control lines to the direct connector |
| ctl_cable_o | output | CTL_W | Control lines to the cabled connector |
| ctl_direct_rx_i | input | CTL_W | Control return from the direct connector |
| ctl_cable_rx_i | input | CTL_W | Control return from the cabled connector |
| ctl_rx_o | output | CTL_W | Selected control return |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |

## Verification
The bench builds the block with ADDR_W = 8 and MAX_BYTES = 40. The upper half therefore starts at word 128, and a full capture is only ten words long. With these values, clamping an oversized limit, stopping on a small limit and a zero limit each take only a few dozen cycles, and the base address is easy to check. The bench holds ready low to force a stall for the overflow and hold cases. It drives noise on the unselected link so that every capture also shows that the connector choice steers the data.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2,
    ST_FLUSH = 2'd3
  } acq_state_e;

  localparam logic [2:0] CMD_SEL_DIRECT = 3'd1;
  localparam logic [2:0] CMD_SEL_CABLE  = 3'd2;
  localparam logic [2:0] CMD_START      = 3'd3;
  localparam logic [2:0] CMD_STOP       = 3'd4;
  localparam logic [2:0] CMD_CLEAR      = 3'd5;

  localparam logic [1:0] RA_CMD    = 2'd0;
  localparam logic [1:0] RA_LIMIT  = 2'd1;
  localparam logic [1:0] RA_STATUS = 2'd2;
  localparam logic [1:0] RA_COUNT  = 2'd3;
endpackage

// File: rtl/acq_cmd_decode.sv
module acq_cmd_decode
  import acq_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int MAX_WORDS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             busy_i,
  output logic             start_o,
  output logic             stop_o,
  output logic             clear_o,
  output logic             sel_o,
  output logic [CNT_W-1:0] limit_o
);
  localparam logic [29:0]      MAX_W30 = 30'(MAX_WORDS);
  localparam logic [CNT_W-1:0] MAX_WN  = CNT_W'(MAX_WORDS);

  logic       cmd_we;
  logic [2:0] code;

  assign cmd_we  = we_i && (addr_i == RA_CMD);
  assign code    = wdata_i[2:0];
  assign start_o = cmd_we && (code == CMD_START);
  assign stop_o  = cmd_we && (code == CMD_STOP);
  assign clear_o = cmd_we && (code == CMD_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o <= 1'b0;
    end else if (cmd_we && !busy_i) begin
      if (code == CMD_SEL_DIRECT)     sel_o <= 1'b0;
      else if (code == CMD_SEL_CABLE) sel_o <= 1'b1;
    end
  end

  // limit kept in words; byte value is clamped, low two bits dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_o <= MAX_WN;
    end else if (we_i && (addr_i == RA_LIMIT)) begin
      if (wdata_i[31:2] > MAX_W30) limit_o <= MAX_WN;
      else                         limit_o <= wdata_i[CNT_W+1:2];
    end
  end
endmodule

// File: rtl/acq_packer.sv
module acq_packer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        capture_i,
  input  logic        flush_i,
  input  logic        samp_valid_i,
  input  logic [15:0] samp_data_i,
  input  logic        mem_ready_i,
  output logic        mem_valid_o,
  output logic [31:0] mem_wdata_o,
  output logic        fire_o,
  output logic        overflow_o,
  output logic        drained_o
);
  logic        valid_q, half_q;
  logic [15:0] low_q;
  logic [31:0] word_q;
  logic        stall, accept, flush_go;

  assign stall    = valid_q & ~mem_ready_i;
  assign fire_o   = valid_q & mem_ready_i;
  assign accept   = capture_i & samp_valid_i & ~stall;
  assign flush_go = flush_i & half_q & ~stall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      half_q  <= 1'b0;
      low_q   <= '0;
      word_q  <= '0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      if (fire_o) valid_q <= 1'b0;
      if (accept) begin
        if (!half_q) begin
          low_q  <= samp_data_i;
          half_q <= 1'b1;
        end else begin
          word_q  <= {samp_data_i, low_q};
          valid_q <= 1'b1;
          half_q  <= 1'b0;
        end
      end else if (flush_go) begin
        word_q  <= {16'h0000, low_q};
        valid_q <= 1'b1;
        half_q  <= 1'b0;
      end
    end
  end

  assign mem_valid_o = valid_q;
  assign mem_wdata_o = word_q;
  assign overflow_o  = capture_i & samp_valid_i & stall;
  assign drained_o   = ~valid_q & ~half_q;
endmodule

// File: rtl/acq_addr_gen.sv
module acq_addr_gen #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              fire_i,
  input  logic              pending_i,
  input  logic [CNT_W-1:0]  limit_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              limit_hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   issued;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (fire_i)  cnt_q <= cnt_q + 1'b1;
  end

  // one word in flight at most: its slot is the completed count
  assign addr_o      = {1'b1, (ADDR_W-1)'(cnt_q)};
  assign count_o     = cnt_q;
  assign issued      = {1'b0, cnt_q} + {{CNT_W{1'b0}}, pending_i};
  assign limit_hit_o = issued >= {1'b0, limit_i};
endmodule

// File: rtl/acq_capture_ctrl.sv
module acq_capture_ctrl
  import acq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MAX_BYTES = 31457280,
  parameter int CTL_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              link_sel_o,
  input  logic              direct_valid_i,
  input  logic [15:0]       direct_data_i,
  input  logic              cable_valid_i,
  input  logic [15:0]       cable_data_i,
  input  logic [CTL_W-1:0]  ctl_tx_i,
  output logic [CTL_W-1:0]  ctl_direct_o,
  output logic [CTL_W-1:0]  ctl_cable_o,
  input  logic [CTL_W-1:0]  ctl_direct_rx_i,
  input  logic [CTL_W-1:0]  ctl_cable_rx_i,
  output logic [CTL_W-1:0]  ctl_rx_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o
);
  localparam int MAX_WORDS = MAX_BYTES / 4;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int N_LINK    = 2;

  acq_state_e       state_q, state_d;
  logic             ovf_q;
  logic             busy, capture, start_cmd, stop_cmd, clear_cmd, start_ok, restart;
  logic             sel;
  logic [CNT_W-1:0] limit_w, count;
  logic             fire, ovf_p, drained, limit_hit;
  logic             samp_valid;
  logic [15:0]      samp_data;

  logic [N_LINK-1:0]            lk_valid;
  logic [N_LINK-1:0][15:0]      lk_data;
  logic [N_LINK-1:0][CTL_W-1:0] lk_rx, lk_tx;

  assign busy     = (state_q == ST_RUN) || (state_q == ST_FLUSH);
  assign start_ok = start_cmd && !busy;
  assign restart  = start_ok || clear_cmd;
  assign capture  = (state_q == ST_RUN) && !limit_hit;

  acq_cmd_decode #(.CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .busy_i  (busy),
    .start_o (start_cmd),
    .stop_o  (stop_cmd),
    .clear_o (clear_cmd),
    .sel_o   (sel),
    .limit_o (limit_w)
  );

  // connector steering: data and control follow one select
  assign lk_valid = {cable_valid_i, direct_valid_i};
  assign lk_data  = {cable_data_i, direct_data_i};
  assign lk_rx    = {ctl_cable_rx_i, ctl_direct_rx_i};

  for (genvar g = 0; g < N_LINK; g++) begin : g_link
    assign lk_tx[g] = (sel == 1'(g)) ? ctl_tx_i : '0;
  end

  assign samp_valid   = lk_valid[sel];
  assign samp_data    = lk_data[sel];
  assign ctl_rx_o     = lk_rx[sel];
  assign ctl_direct_o = lk_tx[0];
  assign ctl_cable_o  = lk_tx[1];
  assign link_sel_o   = sel;

  acq_packer u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (restart),
    .capture_i    (capture),
    .flush_i      (state_q == ST_FLUSH),
    .samp_valid_i (samp_valid),
    .samp_data_i  (samp_data),
    .mem_ready_i  (mem_ready_i),
    .mem_valid_o  (mem_valid_o),
    .mem_wdata_o  (mem_wdata_o),
    .fire_o       (fire),
    .overflow_o   (ovf_p),
    .drained_o    (drained)
  );

  acq_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (restart),
    .fire_i      (fire),
    .pending_i   (mem_valid_o),
    .limit_i     (limit_w),
    .addr_o      (mem_addr_o),
    .count_o     (count),
    .limit_hit_o (limit_hit)
  );

  always_comb begin
    state_d = state_q;
    if (clear_cmd) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_cmd) state_d = ST_RUN;
        ST_RUN:           if (stop_cmd || limit_hit) state_d = ST_FLUSH;
        ST_FLUSH:         if (drained) state_d = ST_DONE;
        default:          state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (restart)    ovf_q <= 1'b0;
      else if (ovf_p) ovf_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      RA_STATUS: reg_rdata_o = {28'h0, sel, ovf_q, state_q};
      RA_COUNT:  reg_rdata_o = 32'(count);
      RA_LIMIT:  reg_rdata_o = 32'({limit_w, 2'b00});
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/acq_capture_ctrl_chk.sv
module acq_capture_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              busy_i,
  input logic              idle_i,
  input logic              cap_i,
  input logic              ovf_i,
  input logic              sel_i,
  input logic              samp_valid_i,
  input logic              mem_valid_i,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [31:0]       mem_wdata_i
);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i && !mem_ready_i && !clear_i |=>
      mem_valid_i && $stable(mem_addr_i) && $stable(mem_wdata_i));

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i && mem_ready_i && !clear_i |=>
      mem_addr_i == ADDR_W'($past(mem_addr_i) + 1'b1));

  p_sel_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(sel_i));

  p_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && samp_valid_i && mem_valid_i && !mem_ready_i && !clear_i |=> ovf_i);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !mem_valid_i);
endmodule

bind acq_capture_ctrl acq_capture_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_cmd),
  .busy_i       (busy),
  .idle_i       (state_q == acq_pkg::ST_IDLE),
  .cap_i        (capture),
  .ovf_i        (ovf_q),
  .sel_i        (link_sel_o),
  .samp_valid_i (samp_valid),
  .mem_valid_i  (mem_valid_o),
  .mem_ready_i  (mem_ready_i),
  .mem_addr_i   (mem_addr_o),
  .mem_wdata_i  (mem_wdata_o)
);

// File: tb/test_acq_capture_ctrl.sv
module test_acq_capture_ctrl;
  localparam int ADDR_W = 8;
  localparam int MAXB   = 40;
  localparam int BASE   = 128;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  localparam logic [63:0] PACK_VEC [4] = '{
    {16'h1111, 16'h2222, 32'h2222_1111},
    {16'hFFFF, 16'h0000, 32'h0000_FFFF},
    {16'h8001, 16'h7FFE, 32'h7FFE_8001},
    {16'hA5A5, 16'h5A5A, 32'h5A5A_A5A5}
  };

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic link_sel;
  logic dv = 0, cv = 0;
  logic [15:0] dd = 0, cd = 0;
  logic [2:0] ctl_tx = 0, ctl_d_o, ctl_c_o, ctl_rx;
  logic [2:0] drx = 3'b010, crx = 3'b110;
  logic mem_valid, mem_ready = 1;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata;

  logic [31:0] mem_img [256];
  int wr_seen, low_writes;
  logic wipe = 0;
  bit cur_sel = 0;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  acq_capture_ctrl #(.ADDR_W(ADDR_W), .MAX_BYTES(MAXB), .CTL_W(3)) i_acq_capture_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .link_sel_o(link_sel),
    .direct_valid_i(dv), .direct_data_i(dd), .cable_valid_i(cv), .cable_data_i(cd),
    .ctl_tx_i(ctl_tx), .ctl_direct_o(ctl_d_o), .ctl_cable_o(ctl_c_o),
    .ctl_direct_rx_i(drx), .ctl_cable_rx_i(crx), .ctl_rx_o(ctl_rx),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  always @(posedge clk) begin
    if (wipe) begin
      for (int i = 0; i < 256; i++) mem_img[i] <= SENT;
      wr_seen <= 0;
      low_writes <= 0;
    end else if (rst_n && mem_valid && mem_ready) begin
      mem_img[mem_addr] <= mem_wdata;
      wr_seen <= wr_seen + 1;
      if (mem_addr < ADDR_W'(BASE)) low_writes <= low_writes + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [1:0] a, input logic [31:0] exp);
    rd(a, rv);
    chk(tag, rv, exp);
  endtask

  task automatic cmd(input logic [2:0] c);
    reg_wr(2'd0, {29'h0, c});
  endtask

  // selected link carries d, the other carries noise
  task automatic send(input logic [15:0] d);
    @(negedge clk);
    dv = 1; cv = 1;
    dd = cur_sel ? 16'hBAD0 : d;
    cd = cur_sel ? d : 16'hBAD1;
    @(negedge clk);
    dv = 0; cv = 0;
  endtask

  task automatic do_wipe();
    @(negedge clk); wipe = 1;
    @(negedge clk); wipe = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_reg("R1 status", 2'd2, 32'h0);
    chk_reg("R1 count", 2'd3, 32'h0);
    chk_reg("R1 limit", 2'd1, MAXB);
    chk("R1 mem_valid", {31'h0, mem_valid}, 32'h0);
    chk("R1 link_sel", {31'h0, link_sel}, 32'h0);

    // R7 clamp and rounding
    reg_wr(2'd1, 32'd1000); chk_reg("R7 clamp", 2'd1, 32'd40);
    reg_wr(2'd1, 32'd22);   chk_reg("R7 round", 2'd1, 32'd20);
    reg_wr(2'd1, 32'd40);

    // R2 unknown code and idle stop have no effect
    cmd(3'd7); cmd(3'd4);
    chk_reg("R2 ignored codes", 2'd2, 32'h0);

    // R4 R5 vector table
    do_wipe();
    cmd(3'd3);
    chk_reg("R2 capturing", 2'd2, 32'h1);
    for (int i = 0; i < 4; i++) begin
      send(PACK_VEC[i][63:48]);
      send(PACK_VEC[i][47:32]);
      repeat (2) @(negedge clk);
      chk($sformatf("R4 R5 word %0d", i), mem_img[BASE+i], PACK_VEC[i][31:0]);
    end
    cmd(3'd4); settle();
    chk_reg("R6 done", 2'd2, 32'h2);
    chk_reg("R12 count", 2'd3, 32'd4);
    chk("R5 lower half untouched", low_writes, 0);

    // R6 odd sample flushed
    do_wipe();
    cmd(3'd3);
    send(16'hAAAA); send(16'hBBBB); send(16'hCCCC);
    cmd(3'd4); settle();
    chk("R6 pair", mem_img[BASE], 32'hBBBB_AAAA);
    chk("R6 odd flush", mem_img[BASE+1], 32'h0000_CCCC);
    chk_reg("R6 count", 2'd3, 32'd2);

    // R9 start while capturing ignored
    do_wipe();
    cmd(3'd3);
    send(16'h1234);
    cmd(3'd3);
    send(16'h5678);
    cmd(3'd4); settle();
    chk("R9 pair survives", mem_img[BASE], 32'h5678_1234);
    chk_reg("R9 count", 2'd3, 32'd1);

    // R7 limit stop
    do_wipe();
    reg_wr(2'd1, 32'd8);
    cmd(3'd3);
    for (int i = 1; i <= 6; i++) send(16'(i));
    settle();
    chk_reg("R7 done at limit", 2'd2, 32'h2);
    chk_reg("R7 count", 2'd3, 32'd2);
    chk("R7 last word", mem_img[BASE+1], 32'h0004_0003);
    chk("R7 no extra", mem_img[BASE+2], SENT);

    // R7 zero limit
    do_wipe();
    reg_wr(2'd1, 32'd0);
    chk_reg("R7 zero limit", 2'd1, 32'd0);
    cmd(3'd3); settle();
    chk_reg("R7 zero done", 2'd2, 32'h2);
    chk("R7 zero writes", wr_seen, 0);
    reg_wr(2'd1, 32'd40);

    // R8 R11 overflow while stalled
    do_wipe();
    mem_ready = 0;
    cmd(3'd3);
    send(16'h0011); send(16'h0022); send(16'h0033);
    chk_reg("R8 overflow flag", 2'd2, 32'h5);
    chk("R11 hold data", mem_wdata, 32'h0022_0011);
    chk("R11 hold addr", {24'h0, mem_addr}, BASE);
    mem_ready = 1;
    repeat (3) @(negedge clk);
    cmd(3'd4); settle();
    chk_reg("R8 sticky", 2'd2, 32'h6);
    chk_reg("R8 count", 2'd3, 32'd1);
    chk("R8 dropped sample", mem_img[BASE+1], SENT);

    // R9 start from done clears overflow and count
    cmd(3'd3);
    chk_reg("R9 restart status", 2'd2, 32'h1);
    chk_reg("R9 restart count", 2'd3, 32'd0);
    cmd(3'd4); settle();

    // R10 clear
    cmd(3'd5);
    chk_reg("R10 idle", 2'd2, 32'h0);
    chk_reg("R10 limit kept", 2'd1, 32'd40);
    mem_ready = 0;
    cmd(3'd3);
    send(16'h0001); send(16'h0002);
    chk("R10 pending", {31'h0, mem_valid}, 32'h1);
    cmd(3'd5);
    chk("R10 withdrawn", {31'h0, mem_valid}, 32'h0);
    chk_reg("R10 status", 2'd2, 32'h0);
    chk_reg("R10 count", 2'd3, 32'h0);
    mem_ready = 1;

    // R3 connector steering
    cmd(3'd2); cur_sel = 1;
    ctl_tx = 3'b101;
    #1;
    chk("R3 sel cable", {31'h0, link_sel}, 32'h1);
    chk("R3 ctl cable out", {29'h0, ctl_c_o}, 32'h5);
    chk("R3 ctl direct idle", {29'h0, ctl_d_o}, 32'h0);
    chk("R3 ctl rx cable", {29'h0, ctl_rx}, 32'h6);
    do_wipe();
    cmd(3'd3);
    cmd(3'd1);
    chk("R3 select ignored busy", {31'h0, link_sel}, 32'h1);
    send(16'h9ABC); send(16'hDEF0);
    cmd(3'd4); settle();
    chk("R3 cable data", mem_img[BASE], 32'hDEF0_9ABC);
    chk_reg("R3 status sel bit", 2'd2, 32'hA);
    cmd(3'd1); cur_sel = 0;
    #1;
    chk("R3 sel direct", {31'h0, link_sel}, 32'h0);
    chk("R3 ctl direct out", {29'h0, ctl_d_o}, 32'h5);
    chk("R3 ctl rx direct", {29'h0, ctl_rx}, 32'h2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule